// File: doc/BRIEF.md
# Segmented Switch Decoder for a Dual Current-Steering Converter

This block is the digital front end of a two-channel current-steering converter. Each channel, called I and Q, has its own clock and its own synchronous reset. A channel takes a 10-bit straight binary code and splits it into two parts. The five low bits drive five switches weighted 1, 2, 4, 8 and 16 directly. The five high bits become a thermometer code on 31 switches, and each of those switches carries a weight of 32. The split keeps the amount of current that changes at major code steps small: at each multiple of 32, the five binary switches turn off and one segment switch turns on.

A register holds the incoming code before the decoder, and a second register holds the decoded switch word after it. Each switch line has a true output (A) and a complementary output (B). A shared active-high sleep input turns off every switch output on both sides and freezes both register stages in each channel. A monitor output on each channel rebuilds the code from the registered switch word, so a test environment can check the decode without modelling the analog side.

Top module: `segDacFront`

## Requirements
- R1: Switch word bits [4:0] of the A side equal bits [4:0] of the code they were decoded from, with weights 1, 2, 4, 8 and 16.
- R2: Switch word bits [35:5] of the A side are segment lines 0 to 30. The number of segment lines that are on equals code bits [9:5]. Segment line k is on only when segment line k-1 is on.
- R3: A code present at a rising clock edge appears on the switch outputs and the monitor after the next rising edge of the same clock (two register stages).
- R4: While sleep is low, every B line is the complement of its A line.
- R5: Code 1023 turns every A line on. Code 0 turns every B line on.
- R6: When the code goes from a value of the form 32n-1 to 32n (n ≥ 1), the five binary lines go from all on to all off and exactly one more segment line turns on.
- R7: While sleep is high, every A and every B line of both channels is 0.
- R8: While sleep is high, both register stages hold their contents and input changes are ignored. When sleep falls, the outputs at once show the code held before sleep began.
- R9: A low level on a channel's reset at a rising edge of that channel's clock clears both of its stages to code 0: A all zero, B all ones, monitor 0.
- R10: The monitor equals 32 × (number of segment lines on) + (value of the binary lines) of the registered switch word. Outside reset and sleep, it equals the code captured two edges earlier.
- R11: The I and Q channels are independent. A channel's outputs change only at edges of its own clock, its own reset, or sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| iClk | input | 1 | I channel clock, rising edge active |
| iRstN | input | 1 | I channel synchronous reset, active low |
| iData | input | 10 | I channel code |
| qClk | input | 1 | Q channel clock, rising edge active |
| qRstN | input | 1 | Q channel synchronous reset, active low |
| qData | input | 10 | Q channel code |
| sleep | input | 1 | Idle request for both channels, active high |
| iSwA | output | 36 | I channel true switch controls |
| iSwB | output | 36 | I channel complementary switch controls |
| iMon | output | 10 | I channel weighted sum of registered switch word |
| qSwA | output | 36 | Q channel true switch controls |
| qSwB | output | 36 | Q channel complementary switch controls |
| qMon | output | 10 | Q channel weighted sum of registered switch word |

## Verification
The bench sweeps every code on I while Q runs a falling ramp, so each wrap at a multiple of 32 is checked. If the decoder dropped the binary part or compared at the wrong boundary, the segment count would be off by one and the monitor would be wrong by 32. A design with one register stage too few or too many shows the new code one edge early or late. A sleep that only gated the outputs, without freezing the registers, would show the input changed during sleep instead of the held code once sleep falls. The bench stops the Q clock while I keeps running, and checks that Q stays fixed and that a reset on I leaves Q alone. Crossed clock wiring between the channels fails these checks.

// File: rtl/segDacPkg.sv
package segDacPkg;
  // Strobes from the control to each channel datapath
  typedef struct packed {
    logic loadEn;   // both register stages may update
    logic driveEn;  // switch outputs are driven
  } dacStrobe_t;
endpackage

// File: rtl/dacCtrl.sv
module dacCtrl
  import segDacPkg::*;
(
  input  logic       sleep,
  output dacStrobe_t strobe
);
  always_comb begin
    strobe.loadEn  = ~sleep;
    strobe.driveEn = ~sleep;
  end
endmodule

// File: rtl/dacPath.sv
module dacPath
  import segDacPkg::*;
#(
  parameter  int DATA_W = 10,
  parameter  int BIN_W  = 5,
  localparam int SEG_W  = DATA_W - BIN_W,
  localparam int SEG_N  = (2 ** SEG_W) - 1,
  localparam int SW_W   = BIN_W + SEG_N
) (
  input  logic              clk,
  input  logic              rstN,
  input  dacStrobe_t        strobe,
  input  logic [DATA_W-1:0] data,
  output logic [SW_W-1:0]   swA,
  output logic [SW_W-1:0]   swB,
  output logic [DATA_W-1:0] mon
);
  logic [DATA_W-1:0] codeReg;
  logic [SEG_N-1:0]  segLine;
  logic [SW_W-1:0]   swNext;
  logic [SW_W-1:0]   swReg;
  logic [SEG_W-1:0]  upper;
  logic [SEG_W-1:0]  segCount;

  // stage 1: input code register
  always_ff @(posedge clk) begin
    if (!rstN) codeReg <= '0;
    else if (strobe.loadEn) codeReg <= data;
  end

  // thermometer decode of the upper bits
  assign upper = codeReg[DATA_W-1:BIN_W];
  for (genvar k = 0; k < SEG_N; k++) begin : g_seg
    assign segLine[k] = (upper > SEG_W'(k));
  end
  assign swNext = {segLine, codeReg[BIN_W-1:0]};

  // stage 2: switch word register
  always_ff @(posedge clk) begin
    if (!rstN) swReg <= '0;
    else if (strobe.loadEn) swReg <= swNext;
  end

  assign swA = strobe.driveEn ? swReg  : '0;
  assign swB = strobe.driveEn ? ~swReg : '0;

  // weighted sum: each segment is worth 2**BIN_W
  always_comb begin
    segCount = '0;
    for (int k = 0; k < SEG_N; k++) segCount = segCount + SEG_W'(swReg[BIN_W+k]);
  end
  assign mon = {segCount, swReg[BIN_W-1:0]};
endmodule

// File: rtl/segDacFront.sv
module segDacFront
  import segDacPkg::*;
#(
  parameter  int DATA_W = 10,
  parameter  int BIN_W  = 5,
  localparam int SW_W   = BIN_W + (2 ** (DATA_W - BIN_W)) - 1
) (
  input  logic              iClk,
  input  logic              iRstN,
  input  logic [DATA_W-1:0] iData,
  input  logic              qClk,
  input  logic              qRstN,
  input  logic [DATA_W-1:0] qData,
  input  logic              sleep,
  output logic [SW_W-1:0]   iSwA,
  output logic [SW_W-1:0]   iSwB,
  output logic [DATA_W-1:0] iMon,
  output logic [SW_W-1:0]   qSwA,
  output logic [SW_W-1:0]   qSwB,
  output logic [DATA_W-1:0] qMon
);
  localparam int NCH = 2;

  dacStrobe_t        strobe;
  logic              chClk  [NCH];
  logic              chRstN [NCH];
  logic [DATA_W-1:0] chData [NCH];
  logic [SW_W-1:0]   chSwA  [NCH];
  logic [SW_W-1:0]   chSwB  [NCH];
  logic [DATA_W-1:0] chMon  [NCH];

  dacCtrl u_ctrl (.sleep(sleep), .strobe(strobe));

  assign chClk[0]  = iClk;   assign chClk[1]  = qClk;
  assign chRstN[0] = iRstN;  assign chRstN[1] = qRstN;
  assign chData[0] = iData;  assign chData[1] = qData;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dacPath #(.DATA_W(DATA_W), .BIN_W(BIN_W)) u_path (
      .clk(chClk[c]), .rstN(chRstN[c]), .strobe(strobe), .data(chData[c]),
      .swA(chSwA[c]), .swB(chSwB[c]), .mon(chMon[c])
    );
  end

  assign iSwA = chSwA[0];  assign iSwB = chSwB[0];  assign iMon = chMon[0];
  assign qSwA = chSwA[1];  assign qSwB = chSwB[1];  assign qMon = chMon[1];
endmodule

// File: rtl/segDacFrontChk.sv
module segDacFrontChk #(
  parameter  int DATA_W = 10,
  parameter  int BIN_W  = 5,
  localparam int SW_W   = BIN_W + (2 ** (DATA_W - BIN_W)) - 1,
  localparam int SEGW   = SW_W - BIN_W
) (
  input logic              iClk,
  input logic              iRstN,
  input logic [DATA_W-1:0] iData,
  input logic              qClk,
  input logic              qRstN,
  input logic              sleep,
  input logic [SW_W-1:0]   iSwA,
  input logic [SW_W-1:0]   iSwB,
  input logic [DATA_W-1:0] iMon,
  input logic [SW_W-1:0]   qSwA,
  input logic [SW_W-1:0]   qSwB
);
  logic [1:0] iSince;
  always_ff @(posedge iClk) begin
    if (!iRstN) iSince <= '0;
    else if (iSince != 2'd3) iSince <= iSince + 2'd1;
  end

  AST_B_COMPLEMENT: assert property (@(posedge iClk) disable iff (!iRstN)
    !sleep |-> (iSwB == ~iSwA)); // R4
  AST_Q_B_COMPLEMENT: assert property (@(posedge qClk) disable iff (!qRstN)
    !sleep |-> (qSwB == ~qSwA)); // R4
  AST_THERMO_ORDER: assert property (@(posedge iClk) disable iff (!iRstN)
    ((iSwA[SW_W-1:BIN_W] + SEGW'(1)) & iSwA[SW_W-1:BIN_W]) == '0); // R2
  AST_SLEEP_DARK: assert property (@(posedge iClk) disable iff (!iRstN)
    sleep |-> (iSwA == '0 && iSwB == '0 && qSwA == '0 && qSwB == '0)); // R7
  AST_BIN_LINES: assert property (@(posedge iClk) disable iff (!iRstN)
    !sleep |-> (iSwA[BIN_W-1:0] == iMon[BIN_W-1:0])); // R1
  AST_MON_LATENCY: assert property (@(posedge iClk) disable iff (!iRstN)
    (iSince >= 2'd2 && !$past(sleep) && !$past(sleep, 2)) |-> (iMon == $past(iData, 2))); // R10
endmodule

bind segDacFront segDacFrontChk #(.DATA_W(DATA_W), .BIN_W(BIN_W)) u_chk (
  .iClk(iClk), .iRstN(iRstN), .iData(iData), .qClk(qClk), .qRstN(qRstN),
  .sleep(sleep), .iSwA(iSwA), .iSwB(iSwB), .iMon(iMon), .qSwA(qSwA), .qSwB(qSwB)
);

// File: tb/segDacFront_tb_top.sv
module segDacFront_tb_top;
  localparam int DATA_W = 10;
  localparam int BIN_W  = 5;
  localparam int SW_W   = 36;

  logic clk = 1'b0;
  logic qEn = 1'b1;
  logic qClk;
  always #4 clk = ~clk;
  assign qClk = clk & qEn;

  logic iRstN, qRstN, sleep;
  logic [DATA_W-1:0] iData, qData, iMon, qMon;
  logic [SW_W-1:0] iSwA, iSwB, qSwA, qSwB;

  segDacFront dut_i (
    .iClk(clk), .iRstN(iRstN), .iData(iData),
    .qClk(qClk), .qRstN(qRstN), .qData(qData), .sleep(sleep),
    .iSwA(iSwA), .iSwB(iSwB), .iMon(iMon),
    .qSwA(qSwA), .qSwB(qSwB), .qMon(qMon)
  );

  int nRun = 0;
  int nFail = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [SW_W-1:0] expA(input int code);
    int up, bin;
    up  = code >> BIN_W;
    bin = code & ((1 << BIN_W) - 1);
    return (((SW_W'(1) << up) - SW_W'(1)) << BIN_W) | SW_W'(bin);
  endfunction

  function automatic int popSeg(input logic [SW_W-1:0] w);
    return $countones(w[SW_W-1:BIN_W]);
  endfunction

  initial begin
    #(200000 * 8);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [SW_W-1:0] lastA;
    iRstN = 0; qRstN = 0; sleep = 0; iData = '0; qData = '0;
    lastA = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state on both channels
    chk(iSwA == '0 && iMon == '0, "R9 reset I A/mon", {iSwA, iMon}, 0);
    chk(iSwB == '1, "R9 reset I B", iSwB, {SW_W{1'b1}});
    chk(qSwA == '0 && qSwB == '1 && qMon == '0, "R9 reset Q", qSwA, 0);
    iRstN = 1; qRstN = 1;

    // full sweep: I rising, Q falling; outputs lag two edges (R3)
    for (int c = 0; c < 1024 + 2; c++) begin
      @(negedge clk);
      if (c >= 2) begin
        int ci, cq;
        ci = c - 2;
        cq = 1023 - ci;
        chk(iSwA == expA(ci), "R1 R2 I switch word", iSwA, expA(ci));
        chk(iSwB == ~expA(ci), "R4 I complement", iSwB, ~expA(ci));
        chk(iMon == DATA_W'(ci), "R10 I monitor", iMon, ci);
        chk(qSwA == expA(cq) && qMon == DATA_W'(cq), "R11 Q ramp", qMon, cq);
        chk(((iSwA[SW_W-1:BIN_W] + 1'b1) & iSwA[SW_W-1:BIN_W]) == '0, "R2 order", iSwA, expA(ci));
        if (ci == 1023) chk(iSwA == '1, "R5 all ones A", iSwA, {SW_W{1'b1}});
        if (ci == 0)    chk(iSwB == '1, "R5 all zero B", iSwB, {SW_W{1'b1}});
        if (ci > 0 && (ci % 32) == 0)
          chk(iSwA[BIN_W-1:0] == '0 && lastA[BIN_W-1:0] == '1 && popSeg(iSwA) == popSeg(lastA) + 1,
              "R6 major step", iSwA, expA(ci));
        lastA = iSwA;
      end
      iData = (c < 1024) ? DATA_W'(c) : '0;
      qData = (c < 1024) ? DATA_W'(1023 - c) : 10'h333;
    end
    repeat (2) @(negedge clk);

    // R3 latency of exactly two edges
    iData = 10'h2A5;
    @(negedge clk);
    chk(iMon == '0, "R3 not after one edge", iMon, 0);
    @(negedge clk);
    chk(iMon == 10'h2A5 && iSwA == expA(10'h2A5), "R3 after two edges", iMon, 10'h2A5);

    // R7 / R8 sleep
    @(negedge clk);
    sleep = 1;
    #1;
    chk(iSwA == '0 && iSwB == '0 && qSwA == '0 && qSwB == '0, "R7 sleep dark", iSwB, 0);
    iData = 10'h15A;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      chk(iSwA == '0 && iSwB == '0, "R7 sleep stays dark", iSwA, 0);
    end
    sleep = 0;
    #1;
    chk(iMon == 10'h2A5 && iSwA == expA(10'h2A5), "R8 held code on wake", iMon, 10'h2A5);
    @(negedge clk);
    chk(iMon == 10'h2A5, "R8 first edge after wake", iMon, 10'h2A5);
    @(negedge clk);
    chk(iMon == 10'h15A && iSwB == ~expA(10'h15A), "R8 new code after wake", iMon, 10'h15A);

    // R11 independence: stop Q clock
    qEn = 0;
    qData = 10'h0F0;
    iData = 10'h001;
    repeat (4) @(negedge clk);
    chk(qMon == 10'h333 && qSwA == expA(10'h333), "R11 Q frozen without clock", qMon, 10'h333);
    chk(iMon == 10'h001, "R11 I keeps running", iMon, 1);
    qEn = 1;
    repeat (2) @(negedge clk);
    chk(qMon == 10'h0F0 && qSwB == ~expA(10'h0F0), "R11 Q resumes", qMon, 10'h0F0);

    // R9 mid-run reset on I only
    iRstN = 0;
    @(negedge clk);
    chk(iMon == '0 && iSwA == '0 && iSwB == '1, "R9 reset mid-run", iMon, 0);
    chk(qMon == 10'h0F0, "R11 Q ignores I reset", qMon, 10'h0F0);
    iRstN = 1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule